// File: doc/BRIEF.md
# Host Control and Interrupt Register Block

This block gives a host computer that is not itself part of the module network a small set of registers on its memory bus. Through them the host holds the network in reset, puts it into analyse mode, reads the network's wired error state, and receives an interrupt when a link transfer finishes in either direction or when the network reports an error.

The bus side is a plain synchronous port. The host presents an address and a write strobe with write data, or a read strobe; read data appears one cycle after the read strobe. The control outputs are active low. The error input is active low and asynchronous, and it passes through a synchroniser before any logic uses it. Two single-cycle pulses from the link side report that a host-to-board or board-to-host transfer has completed.

Top module: `host_ctrl_regs`

## Requirements
- R1: After reset, `host_reset_n` is low (reset asserted), `host_analyse_n` is high, `irq` is low, and the enable and status registers read 0.
- R2: A write to address 0 drives `host_reset_n` low when write-data bit 0 is 1 and high when it is 0. Data bits 7..1 have no effect.
- R3: A write to address 1 drives `host_analyse_n` low when write-data bit 0 is 1 and high when it is 0. A read of address 1 returns 0, because the register is write-only.
- R4: A read of address 0 returns the synchronised error level in bit 0 (1 while `host_err_n` is low, 0 otherwise) and 0 in bits 7..1. The read does not change the reset latch.
- R5: Address 2 is the interrupt enable register. Bit 0 enables host-to-board done, bit 1 enables board-to-host done and bit 2 enables error. Bits 2..0 can be written and read back. Bits 7..3 read as 0.
- R6: Address 3 is the interrupt status register, using the same bit positions as R5. A one-cycle pulse on `xfer_to_board_done` sets bit 0 and a one-cycle pulse on `xfer_from_board_done` sets bit 1. Each bit stays set until it is cleared.
- R7: Writing 1 to a bit of address 3 clears that status bit, and writing 0 leaves it unchanged. If a set event and a clear arrive in the same cycle, the set wins.
- R8: Status bit 2 is set on the falling edge of the synchronised `host_err_n`. It stays set after the input returns high. After it is cleared, it is not set again while the input stays low.
- R9: `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: Addresses 4 and above read as 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| xfer_to_board_done | input | 1 | Pulse: host-to-board transfer completed |
| xfer_from_board_done | input | 1 | Pulse: board-to-host transfer completed |
| host_err_n | input | 1 | Asynchronous active-low network error |
| host_reset_n | output | 1 | Active-low network reset |
| host_analyse_n | output | 1 | Active-low network analyse |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is the error status bit. It must latch on an edge and not on a level, and it must survive the input returning high. The bench drives `host_err_n` low and back high, with enough cycles between the two for the synchroniser. It then clears the bit while the input is held low, to show that the bit is not set again. Every enable value is swept against every status combination, and each combination is built from the three event sources, so that `irq` is checked as the AND-OR of all 64 pairs. A set pulse is also timed into the same cycle as a clear write to check which one wins.

// File: rtl/host_ctrl_regs.sv
module host_ctrl_regs #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              xfer_to_board_done,
  input  logic              xfer_from_board_done,
  input  logic              host_err_n,
  output logic              host_reset_n,
  output logic              host_analyse_n,
  output logic              irq
);
  localparam int NSRC = 3;
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ANA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(3);

  logic [SYNC_STAGES-1:0] err_sync;
  logic                   err_prev_n;
  logic                   rst_latch, ana_latch;
  logic [NSRC-1:0]        int_en, int_sts;
  logic [DATA_W-1:0]      rd_val;

  wire err_lvl_n = err_sync[SYNC_STAGES-1];
  wire err_fall  = err_prev_n & ~err_lvl_n;
  wire wr_rst    = bus_wr && bus_addr == A_RST;
  wire wr_ana    = bus_wr && bus_addr == A_ANA;
  wire wr_en     = bus_wr && bus_addr == A_EN;
  wire wr_sts    = bus_wr && bus_addr == A_STS;

  wire [NSRC-1:0] sts_set = {err_fall, xfer_from_board_done, xfer_to_board_done};
  wire [NSRC-1:0] sts_clr = wr_sts ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_sync   <= '1;
      err_prev_n <= 1'b1;
    end else begin
      err_sync   <= {err_sync[SYNC_STAGES-2:0], host_err_n};
      err_prev_n <= err_lvl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_latch <= 1'b1;
      ana_latch <= 1'b0;
      int_en    <= '0;
      int_sts   <= '0;
    end else begin
      if (wr_rst) rst_latch <= bus_wdata[0];
      if (wr_ana) ana_latch <= bus_wdata[0];
      if (wr_en)  int_en    <= bus_wdata[NSRC-1:0];
      int_sts <= (int_sts & ~sts_clr) | sts_set;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_RST:   rd_val[0] = ~err_lvl_n;
      A_EN:    rd_val[NSRC-1:0] = int_en;
      A_STS:   rd_val[NSRC-1:0] = int_sts;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign host_reset_n   = ~rst_latch;
  assign host_analyse_n = ~ana_latch;
  assign irq            = |(int_sts & int_en);

  a_r2_reset_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> host_reset_n == !$past(bus_wdata[0]));
  a_r3_analyse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ana |=> host_analyse_n == !$past(bus_wdata[0]));
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sts[0] && !wr_sts) |=> int_sts[0]);
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && bus_wdata[1] && !xfer_from_board_done) |=> !int_sts[1]);
  a_r8_error_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_lvl_n) |=> int_sts[2]);
  a_r10_unused_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > A_STS) |=> ($stable(int_en) && $stable(host_reset_n) && $stable(host_analyse_n)));
endmodule

// File: tb/tb_host_ctrl_regs.sv
module tb_host_ctrl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       to_done = 1'b0, from_done = 1'b0, err_n = 1'b1;
  logic       host_reset_n, host_analyse_n, irq;
  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  host_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .xfer_to_board_done(to_done), .xfer_from_board_done(from_done),
    .host_err_n(err_n), .host_reset_n(host_reset_n),
    .host_analyse_n(host_analyse_n), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_n = 1'b0;
    repeat (4) @(negedge clk);
    err_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_to();
    @(negedge clk); to_done = 1'b1; @(negedge clk); to_done = 1'b0;
  endtask

  task automatic pulse_from();
    @(negedge clk); from_done = 1'b1; @(negedge clk); from_done = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset_n", host_reset_n, 0);
    check("R1 analyse_n", host_analyse_n, 1);
    check("R1 irq", irq, 0);
    rd(4'd2, rv); check("R1 enables", rv, 0);
    rd(4'd3, rv); check("R1 status", rv, 0);

    // R2 / R3 sweep over all data bytes
    for (int d = 0; d < 256; d++) begin
      wr(4'd0, 8'(d)); check("R2 reset latch", host_reset_n, (d & 1) ? 0 : 1);
      wr(4'd1, 8'(d)); check("R3 analyse latch", host_analyse_n, (d & 1) ? 0 : 1);
    end
    rd(4'd1, rv); check("R3 analyse reads zero", rv, 0);

    // R4 error level read, read leaves reset latch alone
    wr(4'd0, 8'h01);
    rd(4'd0, rv); check("R4 error idle", rv, 0);
    @(negedge clk); err_n = 1'b0; repeat (3) @(negedge clk);
    rd(4'd0, rv); check("R4 error asserted", rv, 1);
    check("R4 reset latch unchanged by read", host_reset_n, 0);
    err_n = 1'b1; repeat (3) @(negedge clk);
    rd(4'd0, rv); check("R4 error released", rv, 0);
    wr(4'd3, 8'h07);

    // R5 enable readback, all values
    for (int e = 0; e < 256; e++) begin
      wr(4'd2, 8'(e)); rd(4'd2, rv); check("R5 enable readback", rv, e & 7);
    end

    // R10 unused addresses
    wr(4'd2, 8'h05); wr(4'd0, 8'h00); wr(4'd1, 8'h01);
    for (int a = 4; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), rv); check("R10 unused read", rv, 0);
      rd(4'd2, rv); check("R10 enable kept", rv, 5);
      check("R10 reset kept", host_reset_n, 1);
      check("R10 analyse kept", host_analyse_n, 0);
    end
    wr(4'd1, 8'h00);

    // R6 sticky and R7 W1C
    wr(4'd2, 8'h00);
    pulse_to(); repeat (3) @(negedge clk);
    rd(4'd3, rv); check("R6 to-board sticky", rv, 1);
    pulse_from();
    rd(4'd3, rv); check("R6 from-board sticky", rv, 3);
    wr(4'd3, 8'h00); rd(4'd3, rv); check("R7 write zero keeps", rv, 3);
    wr(4'd3, 8'h01); rd(4'd3, rv); check("R7 clear bit0 only", rv, 2);
    // simultaneous set and clear
    @(negedge clk); bus_addr = 4'd3; bus_wdata = 8'h02; bus_wr = 1'b1; from_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; from_done = 1'b0;
    rd(4'd3, rv); check("R7 set wins over clear", rv, 2);
    wr(4'd3, 8'h07); rd(4'd3, rv); check("R7 clear all", rv, 0);

    // R8 edge behaviour
    pulse_err();
    rd(4'd3, rv); check("R8 error sticky after release", rv, 4);
    @(negedge clk); err_n = 1'b0; repeat (4) @(negedge clk);
    wr(4'd3, 8'h04); repeat (4) @(negedge clk);
    rd(4'd3, rv); check("R8 no re-set while low", rv, 0);
    err_n = 1'b1; repeat (4) @(negedge clk);

    // R9 full sweep of enable x status
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        wr(4'd3, 8'h07);
        wr(4'd2, 8'(e));
        if (s & 1) pulse_to();
        if (s & 2) pulse_from();
        if (s & 4) pulse_err();
        rd(4'd3, rv); check("R9 status built", rv, s);
        check("R9 irq", irq, ((e & s) != 0) ? 1 : 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule